// File: doc/BRIEF.md
# Complementary PWM Timer with Dead-Time Insertion

This block is a 16-bit reloading PWM timer that drives two complementary outputs for a half-bridge style load. A prescaler divides the system clock by a power of two. A counter steps once per prescaler tick, runs up to a programmed reload value and then restarts at one. The main waveform level changes when the count passes a compare value and again when the reload value is reached. The primary output follows that level and the complementary output follows its inverse. On every level change, both outputs are held inactive for a programmable number of system clocks before the newly active output is driven high.

Software sets up the timer through simple register writes while the timer is stopped, then sets the enable bit. The first period can begin from any start count. Every later period begins at one. While the timer runs, writes to the compare, reload, dead-time, polarity and prescale fields are staged and take effect at the next reload, so no period is cut short or stretched. Each reload raises a one-clock interrupt pulse.

Top module: `pwm_dt_top`

## Requirements
- R1: After reset, both outputs and the interrupt are low, and the timer is stopped.
- R2: Register address 4 is control: bit 0 enables, bit 1 sets polarity, bits 4:2 set the prescale exponent n. The counter advances once every 2^n system clocks, so one PWM period is reload × 2^n clocks.
- R3: With polarity 0, the main level is high while the count is above the compare value (address 1) and at or below the reload value (address 2). The primary output `pwm_hi` is therefore high for (reload − compare) × 2^n − D clocks per period, and `pwm_lo` is high for compare × 2^n − D clocks, where D is the dead time (address 3).
- R4: With polarity 1, the main level is inverted: `pwm_hi` is high for compare × 2^n − D clocks and `pwm_lo` is high for (reload − compare) × 2^n − D clocks per period.
- R5: After each level change, both outputs stay low for exactly D system clocks before the newly active output rises. The two outputs are never high in the same clock.
- R6: Every reload produces a `reload_irq` pulse exactly one clock wide, and the count is 1 in the clock of that pulse. Pulses are reload × 2^n clocks apart.
- R7: The start count (address 0) is loaded only while the timer is stopped. The first reload after enable comes (reload − start + 1) ticks after counting begins. All later periods are a full reload ticks long.
- R8: A write to the compare, reload, dead-time, polarity or prescale fields while the timer runs takes effect only at the next reload. The period in progress keeps its old length.
- R9: While the enable bit is 0, both outputs and the interrupt are held low.
- R10: A start-count write made while the timer runs does not change the length of any running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select (0 start, 1 compare, 2 reload, 3 dead time, 4 control) |
| cfg_wdata | input | 16 | Write data |
| pwm_hi | output | 1 | Primary PWM output |
| pwm_lo | output | 1 | Complementary PWM output |
| reload_irq | output | 1 | One-clock pulse on each reload |

## Verification
The bench measures high times and periods of both outputs with the prescaler at 1 and at 4, and with the dead time at zero and at several non-zero values. A design that started the dead time one clock late, or released the wrong output, would show a high time off by one and a gap that does not match D. It compares the time to the first interrupt for two start counts, to catch a design that reused the start count after a reload or ignored it. It also rewrites the reload value and the start count in the middle of a period. A design without staging would give a shortened or lengthened current period, which shows up as a wrong interval between interrupts.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  // register select codes
  localparam int unsigned SEL_START  = 0;
  localparam int unsigned SEL_CMP    = 1;
  localparam int unsigned SEL_RELOAD = 2;
  localparam int unsigned SEL_DEAD   = 3;
  localparam int unsigned SEL_CTRL   = 4;

  // control word bit positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_POL_BIT = 1;
  localparam int unsigned CTRL_PRE_LSB = 2;

  // number of prescaler stages needed for a given exponent width
  function automatic int unsigned div_stages(input int unsigned pre_w);
    return (1 << pre_w) - 1;
  endfunction

  // the main waveform level for a count against a compare value
  function automatic logic main_level(input logic pol, input logic above_cmp);
    return pol ^ above_cmp;
  endfunction

endpackage

// File: rtl/pwm_dt_regs.sv
module pwm_dt_regs
  import pwm_dt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DB_W   = 8,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              reload_ev,
  output logic              en,
  output logic [CNT_W-1:0]  start_val,
  output logic [CNT_W-1:0]  cmp_act,
  output logic [CNT_W-1:0]  rld_act,
  output logic [DB_W-1:0]   db_act,
  output logic              pol_act,
  output logic [PRE_W-1:0]  pre_act
);

  // programmed values, written by software
  logic [CNT_W-1:0] cmp_prog;
  logic [CNT_W-1:0] rld_prog;
  logic [DB_W-1:0]  db_prog;
  logic             pol_prog;
  logic [PRE_W-1:0] pre_prog;
  logic             stage_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      start_val <= '0;
      cmp_prog  <= '0;
      rld_prog  <= '0;
      db_prog   <= '0;
      pol_prog  <= 1'b0;
      pre_prog  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(SEL_START) && !en) start_val <= wdata;
      if (addr == ADDR_W'(SEL_CMP))          cmp_prog  <= wdata;
      if (addr == ADDR_W'(SEL_RELOAD))       rld_prog  <= wdata;
      if (addr == ADDR_W'(SEL_DEAD))         db_prog   <= wdata[DB_W-1:0];
      if (addr == ADDR_W'(SEL_CTRL)) begin
        en       <= wdata[CTRL_EN_BIT];
        pol_prog <= wdata[CTRL_POL_BIT];
        pre_prog <= wdata[CTRL_PRE_LSB +: PRE_W];
      end
    end
  end

  // working copies follow the programmed ones while stopped,
  // and only at a reload while running
  assign stage_load = !en || reload_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
      rld_act <= '0;
      db_act  <= '0;
      pol_act <= 1'b0;
      pre_act <= '0;
    end else if (stage_load) begin
      cmp_act <= cmp_prog;
      rld_act <= rld_prog;
      db_act  <= db_prog;
      pol_act <= pol_prog;
      pre_act <= pre_prog;
    end
  end

endmodule

// File: rtl/pwm_dt_prescaler.sv
module pwm_dt_prescaler
  import pwm_dt_pkg::*;
#(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             tick
);

  localparam int unsigned DIV_W = div_stages(PRE_W);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // one mask bit per active divider stage
  generate
    for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
      assign mask[gi] = (gi < int'(pre_sel));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!en) div_q <= '0;
    else          div_q <= div_q + DIV_W'(1);
  end

  assign tick = en && ((div_q & mask) == mask);

endmodule

// File: rtl/pwm_dt_counter.sv
module pwm_dt_counter
  import pwm_dt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic [CNT_W-1:0] rld_act,
  input  logic             pol_act,
  output logic [CNT_W-1:0] cnt,
  output logic             lvl,
  output logic             reload_ev,
  output logic             irq
);

  logic at_reload;
  logic above_cmp;

  assign at_reload = (cnt == rld_act);
  assign above_cmp = (cnt > cmp_act);
  assign reload_ev = en && tick && at_reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= start_val;
    end else if (tick) begin
      if (at_reload) cnt <= CNT_W'(1);
      else           cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      irq <= 1'b0;
    end else begin
      lvl <= en ? main_level(pol_act, above_cmp) : pol_act;
      irq <= reload_ev;
    end
  end

endmodule

// File: rtl/pwm_dt_deadband.sv
module pwm_dt_deadband #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            lvl,
  input  logic [DB_W-1:0] db_act,
  output logic            out_hi,
  output logic            out_lo,
  output logic            dead_busy
);

  logic            lvl_prev;
  logic [DB_W-1:0] dt_q;
  logic [DB_W-1:0] dt_next;
  logic            lvl_edge;
  logic            release_ok;

  assign lvl_edge   = (lvl != lvl_prev);
  assign dead_busy  = (dt_q != '0);

  always_comb begin
    if (lvl_edge)       dt_next = db_act;
    else if (dead_busy) dt_next = dt_q - DB_W'(1);
    else                dt_next = '0;
  end

  assign release_ok = (dt_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= 1'b0;
      dt_q     <= '0;
      out_hi   <= 1'b0;
      out_lo   <= 1'b0;
    end else if (!en) begin
      lvl_prev <= lvl;
      dt_q     <= '0;
      out_hi   <= 1'b0;
      out_lo   <= 1'b0;
    end else begin
      lvl_prev <= lvl;
      dt_q     <= dt_next;
      out_hi   <= release_ok &&  lvl;
      out_lo   <= release_ok && !lvl;
    end
  end

endmodule

// File: rtl/pwm_dt_top.sv
module pwm_dt_top
  import pwm_dt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DB_W   = 8,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              pwm_hi,
  output logic              pwm_lo,
  output logic              reload_irq
);

  // named internal events, visible to the checker
  logic             en_w;
  logic             tick_w;
  logic             reload_ev_w;
  logic [CNT_W-1:0] cnt_w;
  logic             lvl_w;
  logic             dead_busy_w;
  logic [CNT_W-1:0] start_w;
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] rld_w;
  logic [DB_W-1:0]  db_w;
  logic             pol_w;
  logic [PRE_W-1:0] pre_w;

  pwm_dt_regs #(
    .CNT_W(CNT_W), .DB_W(DB_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .reload_ev(reload_ev_w), .en(en_w), .start_val(start_w), .cmp_act(cmp_w),
    .rld_act(rld_w), .db_act(db_w), .pol_act(pol_w), .pre_act(pre_w)
  );

  pwm_dt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .pre_sel(pre_w), .tick(tick_w)
  );

  pwm_dt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_w), .start_val(start_w),
    .cmp_act(cmp_w), .rld_act(rld_w), .pol_act(pol_w), .cnt(cnt_w),
    .lvl(lvl_w), .reload_ev(reload_ev_w), .irq(reload_irq)
  );

  pwm_dt_deadband #(.DB_W(DB_W)) dead_i (
    .clk(clk), .rst_n(rst_n), .en(en_w), .lvl(lvl_w), .db_act(db_w),
    .out_hi(pwm_hi), .out_lo(pwm_lo), .dead_busy(dead_busy_w)
  );

endmodule

// File: rtl/pwm_dt_checker.sv
module pwm_dt_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             out_hi,
  input logic             out_lo,
  input logic             dead_busy
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(out_hi && out_lo)); // R5
  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) dead_busy |-> (!out_hi && !out_lo)); // R5
  AST_IRQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (cnt == CNT_W'(1))); // R6
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n) (en && !tick) |=> $stable(cnt)); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!out_hi && !out_lo && !irq)); // R9

endmodule

bind pwm_dt_top pwm_dt_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_w), .tick(tick_w), .cnt(cnt_w),
  .irq(reload_irq), .out_hi(pwm_hi), .out_lo(pwm_lo), .dead_busy(dead_busy_w)
);

// File: tb/pwm_dt_top_tb_top.sv
`timescale 1ns/1ps
module pwm_dt_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pwm_hi, pwm_lo, reload_irq;

  int checks = 0, fails = 0;
  int cyc = 0;
  int irq_n = 0, irq_t1 = 0, irq_t2 = 0, irq_wide = 0, overlap = 0;
  int en_time = 0;
  bit irq_prev_s = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dt_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .reload_irq(reload_irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (reload_irq) begin
      if (irq_prev_s) irq_wide++;
      irq_n++;
      irq_t1 = irq_t2;
      irq_t2 = cyc;
    end
    irq_prev_s = reload_irq;
    if (pwm_hi && pwm_lo) overlap++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit sig(input int sel);
    case (sel)
      0:       return pwm_hi;
      1:       return pwm_lo;
      default: return reload_irq;
    endcase
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int ctrl_word(input bit en, input bit pol, input int n);
    return (n << 2) | (int'(pol) << 1) | int'(en);
  endfunction

  task automatic setup(input int start, input int cmp, input int rld,
                       input int db, input bit pol, input int n);
    wr(4, ctrl_word(1'b0, pol, n));
    wr(0, start);
    wr(1, cmp);
    wr(2, rld);
    wr(3, db);
    repeat (3) @(negedge clk);
    wr(4, ctrl_word(1'b1, pol, n));
    en_time = cyc;
  endtask

  task automatic measure(input int sel, output int hi, output int per);
    bit prev, cur, high_ph;
    int guard = 0;
    hi = -1; per = -1;
    @(negedge clk); prev = sig(sel);
    forever begin
      @(negedge clk); cur = sig(sel);
      if (!prev && cur) break;
      prev = cur;
      if (++guard > 4000) return;
    end
    hi = 1; per = 1; high_ph = 1'b1; guard = 0;
    forever begin
      @(negedge clk); cur = sig(sel);
      if (high_ph && cur) hi++;
      else if (high_ph && !cur) high_ph = 1'b0;
      else if (!high_ph && cur) break;
      per++;
      if (++guard > 4000) begin per = -1; return; end
    end
  endtask

  task automatic measure_gap(output int gap);
    bit prev, cur;
    int guard = 0;
    gap = -1;
    @(negedge clk); prev = pwm_hi;
    forever begin
      @(negedge clk); cur = pwm_hi;
      if (prev && !cur) break;
      prev = cur;
      if (++guard > 4000) return;
    end
    gap = pwm_lo ? 0 : 1;
    if (gap == 0) return;
    forever begin
      @(negedge clk);
      if (!pwm_hi && !pwm_lo) gap++;
      else break;
      if (gap > 4000) return;
    end
  endtask

  task automatic wait_irqs(input int k);
    int target = irq_n + k;
    int guard = 0;
    while (irq_n < target && guard < 8000) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "pwm_hi after reset", int'(pwm_hi), 0);
    check("R1", "pwm_lo after reset", int'(pwm_lo), 0);
    check("R1", "irq after reset", int'(reload_irq), 0);
  endtask

  task automatic t_basic_duty();
    int hi, per;
    setup(1, 3, 10, 0, 1'b0, 0);
    measure(0, hi, per);
    check("R3", "hi high time n0", hi, 7);
    check("R2", "period n0", per, 10);
    measure(1, hi, per);
    check("R3", "lo high time n0", hi, 3);
  endtask

  task automatic t_prescale_dead();
    int hi, per, gap;
    setup(1, 2, 5, 1, 1'b0, 2);
    measure(0, hi, per);
    check("R3", "hi high time n2", hi, 3 * 4 - 1);
    check("R2", "period n2", per, 5 * 4);
    measure(1, hi, per);
    check("R3", "lo high time n2", hi, 2 * 4 - 1);
    measure_gap(gap);
    check("R5", "gap d1", gap, 1);
  endtask

  task automatic t_deadband();
    int hi, per, gap;
    overlap = 0;
    setup(1, 4, 12, 3, 1'b0, 0);
    measure(0, hi, per);
    check("R5", "hi high time d3", hi, 8 - 3);
    measure(1, hi, per);
    check("R5", "lo high time d3", hi, 4 - 3);
    measure_gap(gap);
    check("R5", "gap d3", gap, 3);
    check("R5", "overlap cycles", overlap, 0);
  endtask

  task automatic t_polarity();
    int hi, per;
    setup(1, 3, 10, 2, 1'b1, 0);
    measure(0, hi, per);
    check("R4", "hi high time inverted", hi, 3 - 2);
    check("R4", "period inverted", per, 10);
    measure(1, hi, per);
    check("R4", "lo high time inverted", hi, 7 - 2);
  endtask

  task automatic t_irq();
    irq_wide = 0;
    setup(1, 2, 6, 0, 1'b0, 1);
    wait_irqs(1);
    wait_irqs(1);
    check("R6", "irq interval", irq_t2 - irq_t1, 12);
    wait_irqs(1);
    check("R6", "irq interval again", irq_t2 - irq_t1, 12);
    check("R6", "irq wider than one clock", irq_wide, 0);
  endtask

  task automatic t_first_period();
    int first_a, first_b;
    setup(1, 3, 10, 0, 1'b0, 1);
    wait_irqs(1);
    first_a = irq_t2 - en_time;
    wait_irqs(1);
    check("R7", "second period from start 1", irq_t2 - irq_t1, 20);
    setup(6, 3, 10, 0, 1'b0, 1);
    wait_irqs(1);
    first_b = irq_t2 - en_time;
    wait_irqs(1);
    check("R7", "second period from start 6", irq_t2 - irq_t1, 20);
    check("R7", "first period shortening", first_a - first_b, 5 * 2);
  endtask

  task automatic t_deferred();
    setup(1, 3, 10, 0, 1'b0, 0);
    wait_irqs(1);
    wr(2, 16);
    wait_irqs(1);
    check("R8", "period in progress keeps old reload", irq_t2 - irq_t1, 10);
    wait_irqs(1);
    check("R8", "new reload after boundary", irq_t2 - irq_t1, 16);
  endtask

  task automatic t_start_running();
    setup(1, 3, 10, 0, 1'b0, 0);
    wait_irqs(1);
    wr(0, 7);
    wait_irqs(1);
    check("R10", "period after start write", irq_t2 - irq_t1, 10);
    wait_irqs(1);
    check("R10", "following period", irq_t2 - irq_t1, 10);
  endtask

  task automatic t_disabled();
    int seen = 0;
    setup(1, 3, 10, 0, 1'b0, 0);
    wait_irqs(1);
    wr(4, ctrl_word(1'b0, 1'b0, 0));
    repeat (2) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_hi || pwm_lo || reload_irq) seen++;
    end
    check("R9", "active cycles while stopped", seen, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic_duty();
    t_prescale_dead();
    t_deadband();
    t_polarity();
    t_irq();
    t_first_period();
    t_deferred();
    t_start_running();
    t_disabled();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

endmodule